// File: doc/BRIEF.md
# Banked Data-Memory Address Resolver and Register Store

This block turns the 7-bit data-memory address issued by a small 8-bit controller into a concrete target. That target is one of four things: on-chip SRAM, the local pointer register, a select strobe for a special register kept in another block, or nothing at all. The address is split into a 5-bit offset and a 2-bit bank number. Offset 00h is never stored anywhere. An access to it in any bank is redirected through the pointer register instead. In that case the pointer's low five bits give the offset and its bits 6:5 give the bank.

Offsets 01h–07h name the same special registers in every bank. Offset 04h is the pointer, which lives inside this block. Offsets 01h timer, 02h program counter, 03h status, 05h port A, 06h port B and 07h port C live elsewhere. For those, the block raises a one-hot strobe and forwards the write data. On a read, it returns the owner's data through `ext_rdata`.

Offsets 08h–0Fh form a window that is common to all banks. Offsets 10h–1Fh are private to each bank. With the default sizes this gives 72 bytes of SRAM. All results appear one clock after the request. Reset is synchronous and active high.

Top module: `banked_regfile`

## Requirements
- R1: After reset the pointer reads 80h, and `rd_vld`, `sfr_sel` and `sfr_we` are all 0.
- R2: A request whose offset bits [4:0] are 00h, in any bank, is redirected to the location named by pointer bits [6:0], with bits [6:5] as bank and [4:0] as offset. Pointer bit 7 is ignored for this.
- R3: When a redirected access lands on offset 00h, a read returns 00h. A write in that case changes no SRAM byte and does not change the pointer. It also raises no strobe.
- R4: Offsets 01h, 02h, 03h, 05h, 06h and 07h, in any bank, drive `sfr_sel` bits 0 to 5 respectively. Exactly one bit is set, one cycle after the request. `sfr_we` and `sfr_wdata` carry the request's write flag and data in that same cycle. Every other target leaves `sfr_sel` at 0.
- R5: Offset 04h in any bank reads and writes the 8-bit pointer. A write is visible on `ptr_o` one cycle after the request.
- R6: Offsets 08h–0Fh refer to the same 8 bytes from every bank.
- R7: Offsets 10h–1Fh refer to 16 bytes per bank that are distinct from those of every other bank.
- R8: A read request (`acc_en`=1, `acc_we`=0) sets `rd_vld` in the next cycle, with `rd_data` valid at that time. When the target is a special register, `rd_data` follows `ext_rdata`.
- R9: With `acc_en` low, nothing is written, `rd_vld` stays 0 and no strobe rises.
- R10: A redirected write whose target is offset 04h overwrites the pointer itself. The next redirected access then uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access request this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 7 | Bank [6:5] and offset [4:0] from the instruction |
| acc_wdata | input | 8 | Write data |
| ext_rdata | input | 8 | Read data returned by the selected external special register |
| rd_data | output | 8 | Read result, valid while rd_vld is high |
| rd_vld | output | 1 | Read result valid (one cycle after a read request) |
| ptr_o | output | 8 | Current pointer register value |
| sfr_sel | output | 6 | One-hot strobe: timer, program counter, status, port A, port B, port C |
| sfr_we | output | 1 | Strobe cycle is a write |
| sfr_wdata | output | 8 | Data forwarded to the strobed special register |

## Verification
Two functions can land in the same cycle. The first is redirection through the pointer. The second is the update of that same pointer, when the pointer names its own offset 04h. The bench sets the pointer to 24h and issues a write to address 00h. It then checks two things. `ptr_o` must carry the written data, not the old value. The following redirected read must resolve through the new pointer to a byte that was preloaded beforehand.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_PTR  = 2'd1,
    TGT_EXT  = 2'd2,
    TGT_MEM  = 2'd3
  } tgt_e;

  // offset of the pointer register inside the special-register slots
  localparam int PTR_OFS  = 4;
  // special registers owned by other blocks (slots 1..7 minus the pointer)
  localparam int NSFR     = 6;
  // first offset of the shared window
  localparam int SFR_SLOTS = 8;

endpackage

// File: rtl/rf_addr_map.sv
module rf_addr_map
  import regfile_pkg::*;
#(
  parameter int AW       = 7,
  parameter int OFS_W    = 5,
  parameter int SHARED_N = 8,
  parameter int BANKED_N = 16,
  parameter int IDX_W    = 7
) (
  input  logic [AW-1:0]    addr,
  input  logic [AW-1:0]    ptr,
  output tgt_e             tgt,
  output logic [IDX_W-1:0] mem_idx,
  output logic [NSFR-1:0]  sfr_hit
);

  localparam int BANK_W = AW - OFS_W;
  localparam logic [OFS_W-1:0] OFS_ZERO    = '0;
  localparam logic [OFS_W-1:0] OFS_PTR     = OFS_W'(PTR_OFS);
  localparam logic [OFS_W-1:0] OFS_SHARED  = OFS_W'(SFR_SLOTS);
  localparam logic [OFS_W-1:0] OFS_BANKED  = OFS_W'(SFR_SLOTS + SHARED_N);

  logic [AW-1:0]     eff;
  logic [OFS_W-1:0]  ofs;
  logic [BANK_W-1:0] bank;
  logic [NSFR-1:0]   code_match;

  // offset 0 in any bank redirects through the pointer
  assign eff  = (addr[OFS_W-1:0] == OFS_ZERO) ? ptr : addr;
  assign ofs  = eff[OFS_W-1:0];
  assign bank = eff[AW-1:OFS_W];

  generate
    for (genvar i = 0; i < NSFR; i++) begin : g_sfr
      localparam logic [OFS_W-1:0] CODE =
        (i < PTR_OFS - 1) ? OFS_W'(i + 1) : OFS_W'(i + 2);
      assign code_match[i] = (ofs == CODE);
    end
  endgenerate

  always_comb begin
    tgt     = TGT_NONE;
    mem_idx = '0;
    sfr_hit = '0;
    if (ofs == OFS_ZERO) begin
      tgt = TGT_NONE;
    end else if (ofs == OFS_PTR) begin
      tgt = TGT_PTR;
    end else if (ofs < OFS_SHARED) begin
      tgt     = TGT_EXT;
      sfr_hit = code_match;
    end else if (ofs < OFS_BANKED) begin
      tgt     = TGT_MEM;
      mem_idx = IDX_W'(ofs - OFS_SHARED);
    end else begin
      tgt     = TGT_MEM;
      mem_idx = IDX_W'(SHARED_N + int'(bank) * BANKED_N + int'(ofs - OFS_BANKED));
    end
  end

endmodule

// File: rtl/rf_sram.sv
module rf_sram #(
  parameter int DW    = 8,
  parameter int DEPTH = 72,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    q
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    q <= mem[idx];
  end

endmodule

// File: rtl/rf_ptr.sv
module rf_ptr #(
  parameter int          DW      = 8,
  parameter logic [7:0]  RST_VAL = 8'h80
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= DW'(RST_VAL);
    else if (we) q <= wdata;
  end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import regfile_pkg::*;
#(
  parameter int DW       = 8,
  parameter int AW       = 7,
  parameter int OFS_W    = 5,
  parameter int SHARED_N = 8,
  parameter int BANKED_N = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            acc_en,
  input  logic            acc_we,
  input  logic [AW-1:0]   acc_addr,
  input  logic [DW-1:0]   acc_wdata,
  input  logic [DW-1:0]   ext_rdata,
  output logic [DW-1:0]   rd_data,
  output logic            rd_vld,
  output logic [DW-1:0]   ptr_o,
  output logic [NSFR-1:0] sfr_sel,
  output logic            sfr_we,
  output logic [DW-1:0]   sfr_wdata
);

  localparam int BANKS = 2 ** (AW - OFS_W);
  localparam int MEM_N = SHARED_N + BANKS * BANKED_N;
  localparam int IDX_W = $clog2(MEM_N);

  tgt_e             tgt;
  logic [IDX_W-1:0] mem_idx;
  logic [NSFR-1:0]  sfr_hit;
  logic [DW-1:0]    mem_q;
  logic             mem_we;
  logic             ptr_we;

  tgt_e             tgt_q;
  logic [DW-1:0]    ptr_snap_q;

  rf_addr_map #(
    .AW(AW), .OFS_W(OFS_W), .SHARED_N(SHARED_N),
    .BANKED_N(BANKED_N), .IDX_W(IDX_W)
  ) map_i (
    .addr    (acc_addr),
    .ptr     (ptr_o[AW-1:0]),
    .tgt     (tgt),
    .mem_idx (mem_idx),
    .sfr_hit (sfr_hit)
  );

  assign mem_we = acc_en && acc_we && (tgt == TGT_MEM);
  assign ptr_we = acc_en && acc_we && (tgt == TGT_PTR);

  rf_sram #(.DW(DW), .DEPTH(MEM_N), .IDX_W(IDX_W)) sram_i (
    .clk   (clk),
    .we    (mem_we),
    .idx   (mem_idx),
    .wdata (acc_wdata),
    .q     (mem_q)
  );

  rf_ptr #(.DW(DW), .RST_VAL(8'h80)) ptr_i (
    .clk   (clk),
    .rst   (rst),
    .we    (ptr_we),
    .wdata (acc_wdata),
    .q     (ptr_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q      <= TGT_NONE;
      ptr_snap_q <= '0;
      rd_vld     <= 1'b0;
      sfr_sel    <= '0;
      sfr_we     <= 1'b0;
      sfr_wdata  <= '0;
    end else begin
      tgt_q      <= acc_en ? tgt : TGT_NONE;
      ptr_snap_q <= ptr_o;
      rd_vld     <= acc_en && !acc_we;
      sfr_sel    <= (acc_en && tgt == TGT_EXT) ? sfr_hit : '0;
      sfr_we     <= acc_en && acc_we && (tgt == TGT_EXT);
      sfr_wdata  <= acc_wdata;
    end
  end

  always_comb begin
    unique case (tgt_q)
      TGT_PTR: rd_data = ptr_snap_q;
      TGT_EXT: rd_data = ext_rdata;
      TGT_MEM: rd_data = mem_q;
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
  parameter int DW    = 8,
  parameter int AW    = 7,
  parameter int OFS_W = 5,
  parameter int NS    = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          acc_en,
  input logic          acc_we,
  input logic [AW-1:0] acc_addr,
  input logic          rd_vld,
  input logic [DW-1:0] ptr_o,
  input logic [NS-1:0] sfr_sel,
  input logic          sfr_we
);

  assert_ptr_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ptr_o == 8'h80 && !rd_vld && sfr_sel == '0));

  assert_null_write_R3: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_we && acc_addr[OFS_W-1:0] == '0 && ptr_o[OFS_W-1:0] == '0)
      |=> (sfr_sel == '0 && $stable(ptr_o)));

  assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sfr_sel));

  assert_sfr_we_has_sel_R4: assert property (@(posedge clk) disable iff (rst)
    sfr_we |-> $countones(sfr_sel) == 1);

  assert_rd_vld_R8: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !acc_we) |=> rd_vld);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !acc_en |=> (!rd_vld && sfr_sel == '0 && $stable(ptr_o)));

endmodule

bind banked_regfile banked_regfile_chk #(
  .DW(DW), .AW(AW), .OFS_W(OFS_W), .NS(regfile_pkg::NSFR)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .acc_en   (acc_en),
  .acc_we   (acc_we),
  .acc_addr (acc_addr),
  .rd_vld   (rd_vld),
  .ptr_o    (ptr_o),
  .sfr_sel  (sfr_sel),
  .sfr_we   (sfr_we)
);

// File: tb/banked_regfile_tb_top.sv
`timescale 1ns/1ps
module banked_regfile_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       acc_en = 1'b0;
  logic       acc_we = 1'b0;
  logic [6:0] acc_addr = '0;
  logic [7:0] acc_wdata = '0;
  logic [7:0] ext_rdata = 8'hC3;
  logic [7:0] rd_data;
  logic       rd_vld;
  logic [7:0] ptr_o;
  logic [5:0] sfr_sel;
  logic       sfr_we;
  logic [7:0] sfr_wdata;

  int nvec = 0;
  int nerr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  banked_regfile dut_i (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .ext_rdata(ext_rdata),
    .rd_data(rd_data), .rd_vld(rd_vld), .ptr_o(ptr_o),
    .sfr_sel(sfr_sel), .sfr_we(sfr_we), .sfr_wdata(sfr_wdata)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // drive at negedge, result registered at next posedge, sampled at next negedge
  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b0; acc_addr = a;
    @(negedge clk);
    acc_en = 1'b0;
    d = rd_data;
    check("R8 rd_vld", {7'd0, rd_vld}, 8'd1);
  endtask

  function automatic logic [5:0] exp_sel(input int o);
    return 6'(1 << ((o < 4) ? o - 1 : o - 2));
  endfunction

  task automatic t_reset;
    check("R1 ptr", ptr_o, 8'h80);
    check("R1 rd_vld", {7'd0, rd_vld}, 8'd0);
    check("R1 sfr_sel", {2'd0, sfr_sel}, 8'd0);
    check("R1 sfr_we", {7'd0, sfr_we}, 8'd0);
  endtask

  task automatic t_shared;
    logic [7:0] d;
    wr(7'h08, 8'h11);
    for (int b = 1; b < 4; b++) begin
      rd(7'(b * 32 + 8), d); check("R6 alias 08h", d, 8'h11);
    end
    wr(7'h6F, 8'h5A);
    rd(7'h0F, d); check("R6 alias 0Fh", d, 8'h5A);
  endtask

  task automatic t_banked;
    logic [7:0] d;
    for (int b = 0; b < 4; b++) begin
      wr(7'(b * 32 + 16), 8'(8'h40 + b));
      wr(7'(b * 32 + 31), 8'(8'hB0 + b));
    end
    for (int b = 0; b < 4; b++) begin
      rd(7'(b * 32 + 16), d); check("R7 bank 10h", d, 8'(8'h40 + b));
      rd(7'(b * 32 + 31), d); check("R7 bank 1Fh", d, 8'(8'hB0 + b));
    end
  endtask

  task automatic t_indirect;
    logic [7:0] d;
    wr(7'h04, 8'hB5);            // bit7 set, bank 1 offset 15h
    check("R5 ptr write", ptr_o, 8'hB5);
    wr(7'h00, 8'h77);
    rd(7'h35, d); check("R2 indirect write", d, 8'h77);
    wr(7'h35, 8'h78);
    rd(7'h40, d); check("R2 redirect from bank2 offset 0", d, 8'h78);
  endtask

  task automatic t_null;
    logic [7:0] d;
    wr(7'h04, 8'h60);            // bank 3 offset 0
    rd(7'h00, d); check("R3 null read", d, 8'h00);
    check("R3 null read sel", {2'd0, sfr_sel}, 8'd0);
    wr(7'h00, 8'hFF);
    check("R3 null write sel", {2'd0, sfr_sel}, 8'd0);
    check("R3 null write ptr", ptr_o, 8'h60);
    rd(7'h70, d); check("R3 bank3 10h untouched", d, 8'h43);
    rd(7'h08, d); check("R3 shared untouched", d, 8'h11);
  endtask

  task automatic t_sfr;
    logic [7:0] d;
    int offs[6] = '{1, 2, 3, 5, 6, 7};
    for (int b = 0; b < 4; b++) begin
      foreach (offs[k]) begin
        ext_rdata = 8'(8'hC0 + b * 8 + k);
        rd(7'(b * 32 + offs[k]), d);
        check("R4 sel", {2'd0, sfr_sel}, {2'd0, exp_sel(offs[k])});
        check("R4 we", {7'd0, sfr_we}, 8'd0);
        check("R8 ext data", d, 8'(8'hC0 + b * 8 + k));
      end
    end
    wr(7'h25, 8'h3C);
    @(negedge clk);
    check("R4 idle after strobe", {2'd0, sfr_sel}, 8'd0);
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b1; acc_addr = 7'h25; acc_wdata = 8'h3C;
    @(negedge clk);
    acc_en = 1'b0; acc_we = 1'b0;
    check("R4 write sel portA", {2'd0, sfr_sel}, 8'h08);
    check("R4 write we", {7'd0, sfr_we}, 8'd1);
    check("R4 write data", sfr_wdata, 8'h3C);
    check("R8 no vld on write", {7'd0, rd_vld}, 8'd0);
    rd(7'h10, d); check("R4 memory read no sel", {2'd0, sfr_sel}, 8'd0);
  endtask

  task automatic t_ptr_banks;
    logic [7:0] d;
    wr(7'h44, 8'h9C);
    check("R5 ptr via bank2", ptr_o, 8'h9C);
    rd(7'h64, d); check("R5 ptr read via bank3", d, 8'h9C);
  endtask

  task automatic t_self;
    logic [7:0] d;
    wr(7'h3E, 8'hA1);            // bank1 offset 1Eh
    wr(7'h04, 8'h24);            // pointer names its own slot in bank 1
    wr(7'h00, 8'h3E);
    check("R10 self overwrite", ptr_o, 8'h3E);
    rd(7'h00, d); check("R10 new pointer used", d, 8'hA1);
  endtask

  task automatic t_idle;
    logic [7:0] d;
    @(negedge clk);
    acc_en = 1'b0; acc_we = 1'b1; acc_addr = 7'h10; acc_wdata = 8'hEE;
    @(negedge clk);
    check("R9 no vld", {7'd0, rd_vld}, 8'd0);
    check("R9 no sel", {2'd0, sfr_sel}, 8'd0);
    acc_we = 1'b0;
    rd(7'h10, d); check("R9 no write", d, 8'h40);
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_shared();
    t_banked();
    t_indirect();
    t_null();
    t_sfr();
    t_ptr_banks();
    t_self();
    t_idle();
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    nvec++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

endmodule